// File: doc/BRIEF.md
# Arithmetic Status Flag Register

This block holds a 16-bit processor status word. After an ALU operation it captures the arithmetic condition flags. Carry, overflow and nibble carry come straight from the ALU. Parity, zero and sign are derived here from the result value, at byte or word width. Three control flags are stored in the same word: single-step trap, interrupt enable and string direction. Each of them moves only on its own set or clear line, or when the whole word is loaded.

The full word is always visible on one output. A load input replaces every defined flag at once, for example when the word is restored from a stack. Bit positions that carry no flag always read as zero. All state changes on the rising clock edge and appears on the output in the next cycle.

Top module: `status_word_reg`

## Requirements
- R1: After a synchronous reset, the whole word reads 0x0000.
- R2: When `upd_i` is high and `load_i` is low, the next word has these bits from the inputs. Bit 0 takes `carry_i`, bit 4 takes `nib_carry_i` and bit 11 takes `ovf_i`.
- R3: On an update, bit 2 is set exactly when bits 7:0 of the result hold an even number of ones, whatever the width select.
- R4: On an update, bit 6 is set when the result is zero at the selected width. With `wide_i` = 0 (byte) this tests bits 7:0; with `wide_i` = 1 (word) it tests bits 15:0.
- R5: On an update, bit 7 copies the result's top bit at the selected width: bit 7 in byte mode, bit 15 in word mode.
- R6: When neither `upd_i` nor `load_i` is high, bits 0, 2, 4, 6, 7 and 11 keep their values.
- R7: Control flags have fixed indices in `ctrl_set_i` and `ctrl_clr_i`. Index 0 is trap (bit 8), index 1 is interrupt enable (bit 9) and index 2 is direction (bit 10). A set line makes its bit 1 and a clear line makes it 0. If both are high, set wins. With neither line high and no load, the bit holds, even while `upd_i` is active.
- R8: When `load_i` is high, the next word equals `load_val_i` AND 0x0FD5. In that cycle the load takes priority over `upd_i` and over every set and clear line.
- R9: Bits 1, 3, 5 and 12 to 15 always read as zero, including right after a load of all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| result_i | input | 16 | ALU result value |
| wide_i | input | 1 | Width select: 0 byte, 1 word |
| carry_i | input | 1 | Carry out of the result's top bit |
| ovf_i | input | 1 | Signed overflow from the ALU |
| nib_carry_i | input | 1 | Carry out of bit 3 (for decimal adjust) |
| upd_i | input | 1 | Capture arithmetic flags this cycle |
| ctrl_set_i | input | 3 | Set lines: [0] trap, [1] interrupt enable, [2] direction |
| ctrl_clr_i | input | 3 | Clear lines, same index order |
| load_i | input | 1 | Load the whole word |
| load_val_i | input | 16 | Word value to load |
| word_o | output | 16 | Current status word |

## Verification
The bench builds the block with its default parameters: a 16-bit word, an 8-bit byte slice and an 8-bit parity slice. These defaults make the byte/word split observable. A result such as 0x1200 is zero as a byte but not as a word, while its parity still comes from the low byte only. The same holds for the sign bit, which moves between bit 7 and bit 15. With these values the bench can also load all ones to expose the undefined positions, and can drive loads, set lines and clear lines in the same cycle to show their priority.

// File: rtl/stwd_pkg.sv
package stwd_pkg;

    localparam int WORD_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int PARITY_W = 8;
    localparam int NUM_CTRL = 3;

    // Fixed bit positions of each flag in the status word
    localparam int CARRY_BIT = 0;
    localparam int PAR_BIT   = 2;
    localparam int AUX_BIT   = 4;
    localparam int ZERO_BIT  = 6;
    localparam int SIGN_BIT  = 7;
    localparam int TRAP_BIT  = 8;
    localparam int INTEN_BIT = 9;
    localparam int DIR_BIT   = 10;
    localparam int OVF_BIT   = 11;

    localparam int CTRL_BASE = TRAP_BIT;

    typedef enum logic {
        WID_BYTE = 1'b0,
        WID_WORD = 1'b1
    } width_e;

    typedef struct packed {
        logic ovf;
        logic sign;
        logic zero;
        logic aux;
        logic par;
        logic carry;
    } arith_t;

    typedef struct packed {
        logic [WORD_W-1:0] result;
        width_e            width;
        logic              carry;
        logic              ovf;
        logic              nib;
    } alu_in_t;

    function automatic logic [WORD_W-1:0] arith_mask();
        logic [WORD_W-1:0] m;
        m = '0;
        m[CARRY_BIT] = 1'b1;
        m[PAR_BIT]   = 1'b1;
        m[AUX_BIT]   = 1'b1;
        m[ZERO_BIT]  = 1'b1;
        m[SIGN_BIT]  = 1'b1;
        m[OVF_BIT]   = 1'b1;
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] defined_mask();
        logic [WORD_W-1:0] m;
        m = arith_mask();
        for (int i = 0; i < NUM_CTRL; i++) m[CTRL_BASE+i] = 1'b1;
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(arith_t a, logic [NUM_CTRL-1:0] c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CARRY_BIT] = a.carry;
        w[PAR_BIT]   = a.par;
        w[AUX_BIT]   = a.aux;
        w[ZERO_BIT]  = a.zero;
        w[SIGN_BIT]  = a.sign;
        w[OVF_BIT]   = a.ovf;
        for (int i = 0; i < NUM_CTRL; i++) w[CTRL_BASE+i] = c[i];
        return w;
    endfunction

    function automatic arith_t unpack_arith(logic [WORD_W-1:0] w);
        arith_t a;
        a.carry = w[CARRY_BIT];
        a.par   = w[PAR_BIT];
        a.aux   = w[AUX_BIT];
        a.zero  = w[ZERO_BIT];
        a.sign  = w[SIGN_BIT];
        a.ovf   = w[OVF_BIT];
        return a;
    endfunction

endpackage

// File: rtl/cond_flag_calc.sv
module cond_flag_calc
    import stwd_pkg::*;
#(
    parameter int DW = WORD_W,
    parameter int BW = BYTE_W,
    parameter int PW = PARITY_W
) (
    input  alu_in_t alu_i,
    output arith_t  flags_o
);
    logic [BW-1:0] byte_slice;
    logic [PW-1:0] par_slice;
    logic          zero_b, zero_w;

    assign byte_slice = alu_i.result[BW-1:0];
    assign par_slice  = alu_i.result[PW-1:0];
    assign zero_b     = (byte_slice == '0);
    assign zero_w     = (alu_i.result == '0);

    always_comb begin
        flags_o.carry = alu_i.carry;
        flags_o.ovf   = alu_i.ovf;
        flags_o.aux   = alu_i.nib;
        flags_o.par   = ~(^par_slice);
        if (alu_i.width == WID_WORD) begin
            flags_o.zero = zero_w;
            flags_o.sign = alu_i.result[DW-1];
        end else begin
            flags_o.zero = zero_b;
            flags_o.sign = alu_i.result[BW-1];
        end
    end
endmodule

// File: rtl/arith_flag_reg.sv
module arith_flag_reg
    import stwd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   upd_i,
    input  arith_t next_i,
    input  logic   load_i,
    input  arith_t load_i_val,
    output arith_t q_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= '0;
        end else if (load_i) begin
            q_o <= load_i_val;
        end else if (upd_i) begin
            q_o <= next_i;
        end
    end
endmodule

// File: rtl/ctrl_flag_bit.sv
module ctrl_flag_bit (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic load_i,
    input  logic load_bit_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= 1'b0;
        end else if (load_i) begin
            q_o <= load_bit_i;
        end else if (set_i) begin
            q_o <= 1'b1;
        end else if (clr_i) begin
            q_o <= 1'b0;
        end
    end
endmodule

// File: rtl/status_word_reg.sv
module status_word_reg
    import stwd_pkg::*;
#(
    parameter int DW = WORD_W,
    parameter int NC = NUM_CTRL
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] result_i,
    input  logic          wide_i,
    input  logic          carry_i,
    input  logic          ovf_i,
    input  logic          nib_carry_i,
    input  logic          upd_i,
    input  logic [NC-1:0] ctrl_set_i,
    input  logic [NC-1:0] ctrl_clr_i,
    input  logic          load_i,
    input  logic [DW-1:0] load_val_i,
    output logic [DW-1:0] word_o
);
    alu_in_t         alu_in;
    arith_t          arith_next;
    arith_t          arith_load;
    arith_t          arith_q;
    logic [NC-1:0]   ctrl_q;

    always_comb begin
        alu_in.result = result_i;
        alu_in.width  = width_e'(wide_i);
        alu_in.carry  = carry_i;
        alu_in.ovf    = ovf_i;
        alu_in.nib    = nib_carry_i;
    end

    assign arith_load = unpack_arith(load_val_i);

    cond_flag_calc u_calc (
        .alu_i   (alu_in),
        .flags_o (arith_next)
    );

    arith_flag_reg u_arith (
        .clk        (clk),
        .rst        (rst),
        .upd_i      (upd_i),
        .next_i     (arith_next),
        .load_i     (load_i),
        .load_i_val (arith_load),
        .q_o        (arith_q)
    );

    for (genvar g = 0; g < NC; g++) begin : g_ctrl
        ctrl_flag_bit u_bit (
            .clk        (clk),
            .rst        (rst),
            .set_i      (ctrl_set_i[g]),
            .clr_i      (ctrl_clr_i[g]),
            .load_i     (load_i),
            .load_bit_i (load_val_i[CTRL_BASE+g]),
            .q_o        (ctrl_q[g])
        );
    end

    assign word_o = pack_word(arith_q, ctrl_q);
endmodule

// File: rtl/status_word_chk.sv
module status_word_chk
    import stwd_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic [15:0]   result_i,
    input logic          carry_i,
    input logic          ovf_i,
    input logic          nib_carry_i,
    input logic          upd_i,
    input logic [2:0]    ctrl_set_i,
    input logic [2:0]    ctrl_clr_i,
    input logic          load_i,
    input logic [15:0]   load_val_i,
    input logic [15:0]   word_o
);
    localparam logic [15:0] DEF_M = 16'h0FD5;
    localparam logic [15:0] ARI_M = 16'h08D5;

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (word_o == 16'h0000));

    // R9
    undef_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (word_o & ~DEF_M) == 16'h0000);

    // R8
    load_word_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (word_o == ($past(load_val_i) & DEF_M)));

    // R6
    arith_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!upd_i && !load_i) |=> ((word_o & ARI_M) == ($past(word_o) & ARI_M)));

    // R2
    direct_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_i && !load_i) |=> (word_o[0] == $past(carry_i) &&
                                word_o[4] == $past(nib_carry_i) &&
                                word_o[11] == $past(ovf_i)));

    // R3
    parity_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_i && !load_i) |=> (word_o[2] == ~(^$past(result_i[7:0]))));

    // R7
    trap_set_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_set_i[0] && !load_i) |=> word_o[8]);

    // R7
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && ctrl_set_i == 3'b000 && ctrl_clr_i == 3'b000) |=> $stable(word_o[10:8]));
endmodule

bind status_word_reg status_word_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .result_i    (result_i),
    .carry_i     (carry_i),
    .ovf_i       (ovf_i),
    .nib_carry_i (nib_carry_i),
    .upd_i       (upd_i),
    .ctrl_set_i  (ctrl_set_i),
    .ctrl_clr_i  (ctrl_clr_i),
    .load_i      (load_i),
    .load_val_i  (load_val_i),
    .word_o      (word_o)
);

// File: tb/status_word_reg_bench.sv
`timescale 1ns/100ps
module status_word_reg_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] result_i;
    logic        wide_i, carry_i, ovf_i, nib_carry_i, upd_i, load_i;
    logic [2:0]  ctrl_set_i, ctrl_clr_i;
    logic [15:0] load_val_i;
    logic [15:0] word_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] model;

    always #2.5 clk = ~clk;

    status_word_reg u_status_word_reg (
        .clk(clk), .rst(rst), .result_i(result_i), .wide_i(wide_i),
        .carry_i(carry_i), .ovf_i(ovf_i), .nib_carry_i(nib_carry_i),
        .upd_i(upd_i), .ctrl_set_i(ctrl_set_i), .ctrl_clr_i(ctrl_clr_i),
        .load_i(load_i), .load_val_i(load_val_i), .word_o(word_o)
    );

    task automatic check(string req, logic [15:0] exp);
        checks++;
        if (word_o !== exp) begin
            errors++;
            $display("FAIL %s: word_o=%04h expected %04h", req, word_o, exp);
        end
    endtask

    task automatic idle();
        result_i = '0; wide_i = 0; carry_i = 0; ovf_i = 0; nib_carry_i = 0;
        upd_i = 0; load_i = 0; ctrl_set_i = '0; ctrl_clr_i = '0; load_val_i = '0;
    endtask

    // Expected arithmetic bits from the written requirements
    function automatic logic [15:0] arith_exp(logic [15:0] r, logic w, logic c, logic o, logic a);
        logic [15:0] e;
        int ones;
        ones = 0;
        for (int i = 0; i < 8; i++) ones += int'(r[i]);
        e = '0;
        e[0]  = c;
        e[2]  = (ones % 2 == 0);
        e[4]  = a;
        e[6]  = w ? (r == 16'h0) : (r[7:0] == 8'h0);
        e[7]  = w ? r[15] : r[7];
        e[11] = o;
        return e;
    endfunction

    task automatic do_update(string req, logic [15:0] r, logic w, logic c, logic o, logic a);
        idle();
        result_i = r; wide_i = w; carry_i = c; ovf_i = o; nib_carry_i = a; upd_i = 1;
        @(negedge clk);
        idle();
        model = (model & 16'h0700) | arith_exp(r, w, c, o, a);
        check(req, model);
    endtask

    task automatic t_reset();
        rst = 1; idle();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        model = 16'h0000;
        check("R1", model);
    endtask

    task automatic t_byte_mode();
        do_update("R2 R3 R4", 16'h1200, 0, 1, 0, 1);      // low byte zero
        do_update("R5", 16'h0080, 0, 0, 1, 0);            // byte sign
        do_update("R4 R5 byte ignores high", 16'h8001, 0, 0, 0, 0);
    endtask

    task automatic t_word_mode();
        do_update("R4 word nonzero", 16'h1200, 1, 0, 0, 0);
        do_update("R5 word sign", 16'h8001, 1, 1, 1, 1);
        do_update("R4 word zero", 16'h0000, 1, 0, 0, 0);
        do_update("R3 parity odd low byte", 16'hFF07, 1, 0, 0, 0);
    endtask

    task automatic t_hold();
        idle();
        result_i = 16'h0000; wide_i = 1; carry_i = 1; ovf_i = 1; nib_carry_i = 1;
        @(negedge clk);
        idle();
        check("R6", model);
    endtask

    task automatic t_ctrl();
        idle(); ctrl_set_i = 3'b001; upd_i = 1; result_i = 16'h0003; wide_i = 0;
        @(negedge clk); idle();
        model = (model & 16'h0700) | arith_exp(16'h0003, 0, 0, 0, 0);
        model[8] = 1;
        check("R7 trap set", model);

        ctrl_set_i = 3'b110; ctrl_clr_i = 3'b110;
        @(negedge clk); idle();
        model[9] = 1; model[10] = 1;
        check("R7 set wins", model);

        ctrl_clr_i = 3'b011;
        @(negedge clk); idle();
        model[8] = 0; model[9] = 0;
        check("R7 clear", model);

        upd_i = 1; result_i = 16'h00FF; wide_i = 0; carry_i = 1;
        @(negedge clk); idle();
        model = (model & 16'h0700) | arith_exp(16'h00FF, 0, 1, 0, 0);
        check("R7 update leaves control", model);
    endtask

    task automatic t_load();
        idle(); load_i = 1; load_val_i = 16'hFFFF;
        @(negedge clk); idle();
        model = 16'h0FD5;
        check("R8 R9 load ones", model);

        load_i = 1; load_val_i = 16'h0000; upd_i = 1; carry_i = 1;
        result_i = 16'h0000; ctrl_set_i = 3'b111;
        @(negedge clk); idle();
        model = 16'h0000;
        check("R8 load priority", model);

        load_i = 1; load_val_i = 16'hA52A;
        @(negedge clk); idle();
        model = 16'hA52A & 16'h0FD5;
        check("R8 load pattern", model);
    endtask

    initial begin
        int cyc;
        cyc = 0;
        fork
            begin
                t_reset();
                t_byte_mode();
                t_word_mode();
                t_hold();
                t_ctrl();
                t_load();
            end
            begin
                while (cyc < 5000) begin
                    @(posedge clk);
                    cyc++;
                end
                checks++; errors++;
                $display("FAIL watchdog: cycles=%0d expected below 5000", cyc);
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule